// File: doc/BRIEF.md
# Page Translation Cache

This block keeps a small set of recently used page mappings and turns a 32-bit virtual address into a physical address in one clock. The address is split at bit 12: the upper 20 bits name a virtual page, and the lower 12 bits are the byte offset inside a 4 KB page, which is copied unchanged into the physical address. A lookup compares the page number against every stored entry at once. On a hit, the result is the stored frame number joined to the offset, together with a fault flag that reports whether the access breaks the entry's permissions.

Each entry holds a page number, a frame number, a read-permission bit, a write-permission bit, a valid bit, a referenced bit and a modified bit. A lookup that is allowed sets the referenced bit of its entry, and an allowed write also sets the modified bit. Each response reports both bits as they stood before the access, so the agent outside can tell when a page is touched or written for the first time. When a lookup misses, an external page-table walker installs the mapping through the refill port. The block chooses where to place it, and a flush input invalidates every entry.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup strobed on `lk_valid` in one cycle is answered in the next cycle with `rsp_valid`=1. On a hit, `rsp_paddr` = {stored frame number, `lk_vaddr[11:0]`}. With no strobe, `rsp_valid` is 0 in the next cycle.
- R2: When no valid entry holds the looked-up page number, the response has `rsp_hit`=0, `rsp_fault`=0, `rsp_paddr`=0 and both previous-bit outputs 0.
- R3: `fill_perm` bit 1 allows writes and bit 0 allows reads. A hit whose access type is not allowed gives `rsp_fault`=1 with `rsp_hit`=1 and the translated address. A fault is never raised on a miss.
- R4: A hit without a fault sets the entry's referenced bit. `rsp_ref_prev` reports that bit as it was before the access. A newly installed entry starts with the bit cleared.
- R5: A write hit without a fault sets the entry's modified bit. A read does not set it, and neither does a faulting write. `rsp_dirty_prev` reports the bit as it was before the access.
- R6: A refill of a page that is not present goes into the lowest-numbered invalid entry.
- R7: When every entry is valid, a refill of a page that is not present replaces the entry named by a rotating pointer. That pointer starts at 0 after reset, advances by one (wrapping) only on such a replacement, and is not changed by a flush.
- R8: A refill of a page number already held by a valid entry overwrites that entry in place, with the new frame number and permissions and cleared referenced and modified bits. No other entry changes, so no page is ever held twice.
- R9: `flush` invalidates all entries at the next clock edge. A refill in the same cycle as a flush is discarded.
- R10: When a lookup and a refill fall in the same cycle, the lookup is answered from the contents before that clock edge. If the refill replaces the entry the lookup hit, the refill's values are kept and the lookup's bit updates are lost.
- R11: After synchronous active-low reset, all entries are invalid and every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_write | input | 1 | Access type of the lookup: 1 write, 0 read |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present (one cycle after the strobe) |
| rsp_hit | output | 1 | Page found |
| rsp_fault | output | 1 | Access not permitted on a hit |
| rsp_paddr | output | 32 | Translated physical address (0 on miss) |
| rsp_ref_prev | output | 1 | Referenced bit of the hit entry before the access |
| rsp_dirty_prev | output | 1 | Modified bit of the hit entry before the access |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 2 | Permissions: bit 1 write allowed, bit 0 read allowed |
| flush | input | 1 | Invalidate all entries |

## Verification
A lookup and a refill can fall in the same clock, and so can a refill and a flush. The bench provokes the first case by filling the table so that the rotating pointer names the entry that a concurrent lookup hits. It then checks that the response carries the old frame, that the old page misses afterwards, and that the new page reports a cleared referenced bit even though the old entry's bit was set. For the flush case, the bench strobes a refill together with a flush and checks that neither the refilled page nor earlier pages are found afterwards.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the page translation cache.
// Assumes 32-bit virtual and physical addresses with 4 KB pages.
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PFN_W  = PA_W - PAGE_W;

    // Access permissions of one page.
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } tlb_perm_t;

    // One refill request as stored into an entry.
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        tlb_perm_t        perm;
    } tlb_fill_t;
endpackage

// File: rtl/tlb_cam_match.sv
`timescale 1ns/1ps
// Parallel key compare across all entries.
// Produces a per-entry hit vector (one-hot while keys are unique) and an
// any-hit flag. Assumes invalid entries must never match.
module tlb_cam_match #(
    parameter int N_ENTRIES = 16,
    parameter int KEY_W     = 20
) (
    input  logic [N_ENTRIES-1:0]            ent_vld,
    input  logic [N_ENTRIES-1:0][KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0]                key,
    output logic [N_ENTRIES-1:0]            hit_vec,
    output logic                            hit_any
);
    // One comparator per entry.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ent_vld[i] && (ent_key[i] == key);
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
// Refill placement: the lowest-numbered invalid entry if there is one,
// otherwise the entry named by a rotating pointer.
// The pointer moves only when it was actually used for a replacement.
// Assumes N_ENTRIES >= 2.
module tlb_victim_sel #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] ent_vld,
    input  logic                 take,
    output logic [N_ENTRIES-1:0] victim_vec,
    output logic                 table_full
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [IDX_W-1:0] pick_idx;

    // Find the lowest invalid entry (scanning down so index 0 wins last).
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign table_full = !free_any;
    assign pick_idx   = free_any ? free_idx : rr_ptr;

    // Turn the chosen index into a one-hot write select.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_sel
        assign victim_vec[i] = (pick_idx == IDX_W'(i));
    end

    // Advance the rotating pointer after a replacement of a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (take && !free_any) begin
            rr_ptr <= (rr_ptr == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
// Storage for all entries. Each entry has one write source for installs
// and one for status updates. Flush beats install, and install beats
// update in the same cycle.
// Assumes wr_vec and upd_vec are each one-hot or zero.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic [N_ENTRIES-1:0]            wr_vec,
    input  tlb_fill_t                       wr_data,
    input  logic [N_ENTRIES-1:0]            upd_vec,
    input  logic                            upd_write,
    output logic [N_ENTRIES-1:0]            ent_vld,
    output logic [N_ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    output logic [N_ENTRIES-1:0][PFN_W-1:0] ent_pfn,
    output logic [N_ENTRIES-1:0]            ent_rd_ok,
    output logic [N_ENTRIES-1:0]            ent_wr_ok,
    output logic [N_ENTRIES-1:0]            ent_refd,
    output logic [N_ENTRIES-1:0]            ent_dirty
);
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic             vld_q;
        logic             refd_q;
        logic             dirty_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PFN_W-1:0] pfn_q;
        tlb_perm_t        perm_q;

        // Hold one entry: reset, flush, install or status update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q   <= 1'b0;
                refd_q  <= 1'b0;
                dirty_q <= 1'b0;
                vpn_q   <= '0;
                pfn_q   <= '0;
                perm_q  <= '0;
            end else if (flush) begin
                vld_q   <= 1'b0;
            end else if (wr_vec[i]) begin
                vld_q   <= 1'b1;
                refd_q  <= 1'b0;
                dirty_q <= 1'b0;
                vpn_q   <= wr_data.vpn;
                pfn_q   <= wr_data.pfn;
                perm_q  <= wr_data.perm;
            end else if (upd_vec[i]) begin
                refd_q  <= 1'b1;
                if (upd_write) begin
                    dirty_q <= 1'b1;
                end
            end
        end

        assign ent_vld[i]   = vld_q;
        assign ent_vpn[i]   = vpn_q;
        assign ent_pfn[i]   = pfn_q;
        assign ent_rd_ok[i] = perm_q.rd_ok;
        assign ent_wr_ok[i] = perm_q.wr_ok;
        assign ent_refd[i]  = refd_q;
        assign ent_dirty[i] = dirty_q;
    end
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
// Fully associative page translation cache (top).
// A lookup is answered one cycle after its strobe, from the contents
// before that edge. Refills place themselves (same page in place, else
// lowest invalid, else rotating pointer). Flush clears all valid bits.
// Assumes the external agent refills only after a miss has been seen.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_ref_prev,
    output logic             rsp_dirty_prev,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_perm,
    input  logic             flush
);
    logic [N_ENTRIES-1:0]            ent_vld;
    logic [N_ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [N_ENTRIES-1:0][PFN_W-1:0] ent_pfn;
    logic [N_ENTRIES-1:0]            ent_rd_ok;
    logic [N_ENTRIES-1:0]            ent_wr_ok;
    logic [N_ENTRIES-1:0]            ent_refd;
    logic [N_ENTRIES-1:0]            ent_dirty;

    logic [VPN_W-1:0]     lk_vpn;
    logic [N_ENTRIES-1:0] lk_hit_vec;
    logic                 lk_any;
    logic [N_ENTRIES-1:0] fill_hit_vec;
    logic                 fill_any;
    logic [N_ENTRIES-1:0] victim_vec;
    logic                 table_full;
    logic                 victim_take;

    logic [PFN_W-1:0]     sel_pfn;
    logic                 sel_rd_ok;
    logic                 sel_wr_ok;
    logic                 sel_refd;
    logic                 sel_dirty;
    logic                 perm_bad;
    logic                 lk_ok;
    logic [N_ENTRIES-1:0] upd_vec;
    logic [N_ENTRIES-1:0] wr_vec;
    tlb_fill_t            wr_data;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_W];

    tlb_cam_match #(.N_ENTRIES(N_ENTRIES), .KEY_W(VPN_W)) u_lk_match (
        .ent_vld (ent_vld),
        .ent_key (ent_vpn),
        .key     (lk_vpn),
        .hit_vec (lk_hit_vec),
        .hit_any (lk_any)
    );

    tlb_cam_match #(.N_ENTRIES(N_ENTRIES), .KEY_W(VPN_W)) u_fill_match (
        .ent_vld (ent_vld),
        .ent_key (ent_vpn),
        .key     (fill_vpn),
        .hit_vec (fill_hit_vec),
        .hit_any (fill_any)
    );

    assign victim_take = fill_en && !fill_any && !flush;

    tlb_victim_sel #(.N_ENTRIES(N_ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_vld    (ent_vld),
        .take       (victim_take),
        .victim_vec (victim_vec),
        .table_full (table_full)
    );

    // AND-OR select of the matching entry's fields (hit vector is one-hot).
    always_comb begin
        sel_pfn   = '0;
        sel_rd_ok = 1'b0;
        sel_wr_ok = 1'b0;
        sel_refd  = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                sel_pfn   = sel_pfn | ent_pfn[i];
                sel_rd_ok = sel_rd_ok | ent_rd_ok[i];
                sel_wr_ok = sel_wr_ok | ent_wr_ok[i];
                sel_refd  = sel_refd | ent_refd[i];
                sel_dirty = sel_dirty | ent_dirty[i];
            end
        end
    end

    // Permission check and update/install selects.
    always_comb begin
        perm_bad     = lk_write ? !sel_wr_ok : !sel_rd_ok;
        lk_ok        = lk_valid && lk_any && !perm_bad;
        upd_vec      = lk_ok ? lk_hit_vec : '0;
        wr_vec       = '0;
        if (fill_en) begin
            wr_vec = fill_any ? fill_hit_vec : victim_vec;
        end
        wr_data.vpn  = fill_vpn;
        wr_data.pfn  = fill_pfn;
        wr_data.perm = tlb_perm_t'(fill_perm);
    end

    tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_vec    (wr_vec),
        .wr_data   (wr_data),
        .upd_vec   (upd_vec),
        .upd_write (lk_write),
        .ent_vld   (ent_vld),
        .ent_vpn   (ent_vpn),
        .ent_pfn   (ent_pfn),
        .ent_rd_ok (ent_rd_ok),
        .ent_wr_ok (ent_wr_ok),
        .ent_refd  (ent_refd),
        .ent_dirty (ent_dirty)
    );

    // Register the lookup response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_ref_prev   <= 1'b0;
            rsp_dirty_prev <= 1'b0;
        end else begin
            rsp_valid      <= lk_valid;
            rsp_hit        <= lk_valid && lk_any;
            rsp_fault      <= lk_valid && lk_any && perm_bad;
            rsp_paddr      <= (lk_valid && lk_any) ?
                              {sel_pfn, lk_vaddr[PAGE_W-1:0]} : '0;
            rsp_ref_prev   <= lk_valid && lk_any && sel_refd;
            rsp_dirty_prev <= lk_valid && lk_any && sel_dirty;
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
// Property checker for tlb_xlate, attached by bind below.
// Watches the ports plus the valid and match vectors between sub-blocks.
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [VA_W-1:0]      lk_vaddr,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_fault,
    input logic [PA_W-1:0]      rsp_paddr,
    input logic                 fill_en,
    input logic                 flush,
    input logic [N_ENTRIES-1:0] ent_vld,
    input logic [N_ENTRIES-1:0] lk_hit_vec,
    input logic [N_ENTRIES-1:0] fill_hit_vec
);
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_fault));

    p_fault_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (ent_vld != '0));

    p_single_lookup_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    p_single_fill_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_hit_vec));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_vld == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr),
    .fill_en      (fill_en),
    .flush        (flush),
    .ent_vld      (ent_vld),
    .lk_hit_vec   (lk_hit_vec),
    .fill_hit_vec (fill_hit_vec)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed
// tests for placement, replacement, collisions, flush and reset.
module sim_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_ref_prev, rsp_dirty_prev;
    logic [31:0] rsp_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_perm = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_ref_prev(rsp_ref_prev),
        .rsp_dirty_prev(rsp_dirty_prev), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush(flush)
    );

    // Row: op(1: refill, 0: lookup) wr perm[1:0] vpn pfn off hit fault ref dirty
    function automatic logic [59:0] row(input logic op, input logic wr,
        input logic [1:0] perm, input logic [19:0] vpn, input logic [19:0] pfn,
        input logic [11:0] off, input logic eh, input logic ef,
        input logic er, input logic ed);
        return {op, wr, perm, vpn, pfn, off, eh, ef, er, ed};
    endfunction

    localparam int NROWS = 16;
    localparam logic [59:0] VEC [0:NROWS-1] = '{
        row(0, 0, 2'd0, 20'h10, 20'h0,     12'h000, 0, 0, 0, 0),
        row(1, 0, 2'd3, 20'h10, 20'hABCDE, 12'h000, 0, 0, 0, 0),
        row(1, 0, 2'd1, 20'h20, 20'h12345, 12'h000, 0, 0, 0, 0),
        row(1, 0, 2'd2, 20'h30, 20'h55555, 12'h000, 0, 0, 0, 0),
        row(0, 0, 2'd0, 20'h10, 20'hABCDE, 12'h123, 1, 0, 0, 0),
        row(0, 1, 2'd0, 20'h10, 20'hABCDE, 12'hFFF, 1, 0, 1, 0),
        row(0, 0, 2'd0, 20'h10, 20'hABCDE, 12'h000, 1, 0, 1, 1),
        row(0, 1, 2'd0, 20'h20, 20'h12345, 12'h004, 1, 1, 0, 0),
        row(0, 0, 2'd0, 20'h20, 20'h12345, 12'h008, 1, 0, 0, 0),
        row(0, 0, 2'd0, 20'h20, 20'h12345, 12'h00C, 1, 0, 1, 0),
        row(0, 0, 2'd0, 20'h30, 20'h55555, 12'h010, 1, 1, 0, 0),
        row(0, 1, 2'd0, 20'h30, 20'h55555, 12'h014, 1, 0, 0, 0),
        row(0, 0, 2'd0, 20'h30, 20'h55555, 12'h018, 1, 1, 1, 1),
        row(1, 0, 2'd3, 20'h10, 20'h77777, 12'h000, 0, 0, 0, 0),
        row(0, 0, 2'd0, 20'h10, 20'h77777, 12'h456, 1, 0, 0, 0),
        row(0, 0, 2'd0, 20'h99, 20'h0,     12'h321, 0, 0, 0, 0)
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, off};
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] perm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic expect_hit(input logic [19:0] vpn, input logic [19:0] pfn, input string req);
        look(vpn, 12'h0A5, 1'b0);
        chk({req, " hit"}, 32'(rsp_hit), 32'd1);
        chk({req, " paddr"}, rsp_paddr, {pfn, 12'h0A5});
    endtask

    task automatic expect_miss(input logic [19:0] vpn, input string req);
        look(vpn, 12'h0A5, 1'b0);
        chk({req, " miss"}, 32'(rsp_hit), 32'd0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [59:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 rsp_valid", 32'(rsp_valid), 0);
        chk("R11 rsp_paddr", rsp_paddr, 0);
        chk("R11 rsp_hit", 32'(rsp_hit), 0);

        // Vector table walk
        for (int k = 0; k < NROWS; k++) begin
            r = VEC[k];
            if (r[59]) begin
                refill(r[55:36], r[35:16], r[57:56]);
            end else begin
                look(r[55:36], r[15:4], r[58]);
                chk("R1 valid", 32'(rsp_valid), 1);
                if (r[3]) begin
                    chk("R1 hit", 32'(rsp_hit), 1);
                    chk("R1 paddr", rsp_paddr, {r[35:16], r[15:4]});
                    chk("R3 fault", 32'(rsp_fault), 32'(r[2]));
                    chk("R4 ref_prev", 32'(rsp_ref_prev), 32'(r[1]));
                    chk("R5 dirty_prev", 32'(rsp_dirty_prev), 32'(r[0]));
                end else begin
                    chk("R2 hit", 32'(rsp_hit), 0);
                    chk("R2 paddr", rsp_paddr, 0);
                    chk("R2 fault", 32'(rsp_fault), 0);
                    chk("R2 ref_prev", 32'(rsp_ref_prev), 0);
                end
            end
        end

        // R6/R8: fill the rest; in-place refill must not have used an entry
        for (int i = 3; i < 16; i++) refill(20'h100 + 20'(i), 20'h800 + 20'(i), 2'd3);
        expect_hit(20'h10, 20'h77777, "R8");
        expect_hit(20'h20, 20'h12345, "R6");
        expect_hit(20'h30, 20'h55555, "R6");
        for (int i = 3; i < 16; i++) expect_hit(20'h100 + 20'(i), 20'h800 + 20'(i), "R6");

        // R7: full table, first replacement takes entry 0
        refill(20'h200, 20'h900, 2'd3);
        expect_miss(20'h10, "R7");
        expect_hit(20'h200, 20'h900, "R7");
        expect_hit(20'h20, 20'h12345, "R7");

        // R10: lookup and refill in one cycle, refill replaces the hit entry
        @(negedge clk);
        lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = {20'h20, 12'h0A5};
        fill_en = 1'b1; fill_vpn = 20'h201; fill_pfn = 20'h901; fill_perm = 2'd3;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0;
        chk("R10 hit", 32'(rsp_hit), 1);
        chk("R10 old paddr", rsp_paddr, {20'h12345, 12'h0A5});
        expect_miss(20'h20, "R10");
        expect_hit(20'h201, 20'h901, "R10");
        chk("R10 ref lost", 32'(rsp_ref_prev), 0);

        // R9: flush with a refill in the same cycle
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h300; fill_pfn = 20'hA00; fill_perm = 2'd3;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        expect_miss(20'h300, "R9");
        expect_miss(20'h200, "R9");
        expect_miss(20'h30, "R9");

        // R6/R7: lowest invalid after flush, pointer kept at 2
        for (int i = 0; i < 16; i++) refill(20'h400 + 20'(i), 20'hB00 + 20'(i), 2'd3);
        refill(20'h500, 20'hC00, 2'd3);
        expect_miss(20'h402, "R7");
        expect_hit(20'h500, 20'hC00, "R7");
        expect_hit(20'h400, 20'hB00, "R6");
        expect_hit(20'h401, 20'hB01, "R6");
        expect_hit(20'h403, 20'hB03, "R6");

        // R11: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 rsp_valid", 32'(rsp_valid), 0);
        chk("R11 rsp_paddr", rsp_paddr, 0);
        expect_miss(20'h400, "R11");

        report();
    end
endmodule